// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Near-Limit Threshold

This block carries 9-bit words from a load clock domain to an unload clock domain through a 1024-word store. Both clocks run freely. A word is accepted on a rising load clock edge when `loadEn` is high and the store has room. A word is handed out on a rising unload clock edge when `unloadEn` is high and the store holds data. Load attempts against a full store and unload attempts against an empty store change nothing.

Four status outputs describe the fill level:
- `notEmpty` and `notFull` use active-low semantics for the empty and full conditions.
- `halfFull` reports the upper half of the store.
- `nearEdge` is a single flag that is high when the store is close to either end. "Close" means within a threshold offset X of empty or of full.

X is loaded from the data input when `defineN` falls. X is committed whenever reset is applied. With `defineN` high during reset, X falls back to 256. With `defineN` held low, the last captured value is kept.

Read and write positions cross between the domains as Gray codes through two-flop synchronizers. Each domain computes the flag that protects it, so that flag can only err toward the safe side. The half-full and near-limit flags come from a fill count formed in the unload domain, so they trail the true level by a few unload cycles.

Top module: `dualClockFifo`

## Requirements
- R1: The store holds 1024 words of 9 bits.
  - A read is accepted on a rising `unloadClk` edge with `unloadEn` high and `notEmpty` high.
  - Each accepted read drives the oldest stored word onto `dataOut` after that edge.
  - Words leave in exactly the order they were accepted.
- R2: A rising `loadClk` edge with `loadEn` high while `notFull` is low stores nothing. The words already stored and the order of later reads are unaffected.
- R3: A rising `unloadClk` edge with `unloadEn` high while `notEmpty` is low leaves `dataOut` and the stored words unchanged.
- R4: Once traffic has stopped for eight `unloadClk` cycles:
  - `notEmpty` is 0 exactly when the store holds no words.
  - `notFull` is 0 exactly when it holds 1024 words.
- R5: Once settled, `halfFull` is 1 when the fill count is 512 or more, and 0 when it is 511 or less.
- R6: Once settled, `nearEdge` is 1 when the count is at most X or at least 1024 − X, and 0 for counts strictly between.
- R7: A high-to-low transition on `defineN` captures `dataIn` as the user offset. `dataIn` must be held stable for at least three `loadClk` cycles after the fall.
- R8: The offset is committed during each reset:
  - With `defineN` high during reset, X becomes 256.
  - With `defineN` low while reset is released, the captured user offset is kept, including across later resets.
- R9: Reset is active low and must be applied once after power-up. After reset: `notEmpty` = 0, `notFull` = 1, `halfFull` = 0, `nearEdge` = 1.
- R10: The flags never err to the unsafe side:
  - `notEmpty` is high only while at least one word is stored.
  - `notFull` is high only while fewer than 1024 words are stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| loadClk | input | 1 | Write-side clock |
| unloadClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| defineN | input | 1 | Threshold strobe; its falling edge captures `dataIn` as the offset |
| loadEn | input | 1 | Write request, sampled on `loadClk` |
| unloadEn | input | 1 | Read request, sampled on `unloadClk` |
| dataIn | input | 9 | Write data and offset value |
| dataOut | output | 9 | Last word read out |
| notEmpty | output | 1 | Low when the store is empty |
| notFull | output | 1 | Low when the store is full |
| halfFull | output | 1 | High at 512 words or more |
| nearEdge | output | 1 | High within X words of empty or of full |

## Verification
Different internal faults show up in different places:
- A corrupted write or read position shows up at the next accepted read, as a word out of order on `dataOut`.
- A position that moves while the store is full or empty appears as a lost or duplicated word when the store is later drained.
- A wrong synchronized pointer or fill count appears as a flag on the unsafe side within one clock of the affected domain. Otherwise it appears as a settled flag that disagrees with the model's count within eight unload cycles.
- A wrong committed offset only appears at the near-limit flag. It is probed at counts on each side of both thresholds, after each way of programming the offset.

// File: rtl/fifoPkg.sv
package fifoPkg;
  // Per-cycle commands from the control to the storage.
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } fifoStrobe_t;
endpackage

// File: rtl/syncStage.sv
module syncStage #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= {W{RST_VAL}};
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/fifoCtrl.sv
module fifoCtrl
  import fifoPkg::*;
#(
  parameter int DATA_W    = 9,
  parameter int ADDR_W    = 10,
  parameter int DEFAULT_X = 256,
  parameter int SYNC_LEN  = 2
) (
  input  logic              loadClk,
  input  logic              unloadClk,
  input  logic              rstN,
  input  logic              defineN,
  input  logic              loadEn,
  input  logic              unloadEn,
  input  logic [DATA_W-1:0] dataIn,
  output fifoStrobe_t       strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              notEmpty,
  output logic              notFull,
  output logic              halfFull,
  output logic              nearEdge
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- load domain ----------------
  logic             wRstN;
  logic [PTR_W-1:0] wBin, wGray, wBinNext;
  logic [PTR_W-1:0] rGraySyncW;
  logic             fullNow, wrGo;

  syncStage #(.W(1), .STAGES(SYNC_LEN), .RST_VAL(1'b0)) i_wRstSync (
    .clk(loadClk), .rstN(rstN), .d(1'b1), .q(wRstN));

  assign fullNow  = (wGray == {~rGraySyncW[PTR_W-1:PTR_W-2], rGraySyncW[PTR_W-3:0]});
  assign wrGo     = loadEn & ~fullNow & wRstN;
  assign wBinNext = wBin + 1'b1;

  always_ff @(posedge loadClk or negedge wRstN) begin
    if (!wRstN) begin
      wBin  <= '0;
      wGray <= '0;
    end else if (wrGo) begin
      wBin  <= wBinNext;
      wGray <= toGray(wBinNext);
    end
  end

  // Threshold strobe: synchronized, falling edge captures the data bus.
  logic              defLvl, defPrev, defFall;
  logic [DATA_W-1:0] userX, appliedX;

  syncStage #(.W(1), .STAGES(SYNC_LEN), .RST_VAL(1'b1)) i_defSync (
    .clk(loadClk), .rstN(1'b1), .d(defineN), .q(defLvl));

  assign defFall = defPrev & ~defLvl;

  always_ff @(posedge loadClk) begin
    defPrev <= defLvl;
    if (defFall) userX <= dataIn;
  end

  // Offset committed only while the load domain is held in reset.
  always_ff @(posedge loadClk) begin
    if (!wRstN) begin
      if (defLvl)       appliedX <= DATA_W'(DEFAULT_X);
      else if (defFall) appliedX <= dataIn;
      else              appliedX <= userX;
    end
  end

  // ---------------- unload domain ----------------
  logic             rRstN;
  logic [PTR_W-1:0] rBin, rGray, rBinNext;
  logic [PTR_W-1:0] wGraySyncR, wBinSyncR, fillCount;
  logic [PTR_W-1:0] lowLim, highLim;
  logic             emptyNow, rdGo;

  syncStage #(.W(1), .STAGES(SYNC_LEN), .RST_VAL(1'b0)) i_rRstSync (
    .clk(unloadClk), .rstN(rstN), .d(1'b1), .q(rRstN));

  assign emptyNow = (rGray == wGraySyncR);
  assign rdGo     = unloadEn & ~emptyNow & rRstN;
  assign rBinNext = rBin + 1'b1;

  always_ff @(posedge unloadClk or negedge rRstN) begin
    if (!rRstN) begin
      rBin  <= '0;
      rGray <= '0;
    end else if (rdGo) begin
      rBin  <= rBinNext;
      rGray <= toGray(rBinNext);
    end
  end

  // ---------------- pointer crossings ----------------
  syncStage #(.W(PTR_W), .STAGES(SYNC_LEN), .RST_VAL(1'b0)) i_rToW (
    .clk(loadClk), .rstN(wRstN), .d(rGray), .q(rGraySyncW));

  syncStage #(.W(PTR_W), .STAGES(SYNC_LEN), .RST_VAL(1'b0)) i_wToR (
    .clk(unloadClk), .rstN(rRstN), .d(wGray), .q(wGraySyncR));

  // ---------------- level flags (unload domain) ----------------
  assign wBinSyncR = fromGray(wGraySyncR);
  assign fillCount = wBinSyncR - rBin;
  assign lowLim    = PTR_W'(appliedX);
  assign highLim   = PTR_W'(DEPTH) - PTR_W'(appliedX);

  assign halfFull = (fillCount >= PTR_W'(HALF));
  assign nearEdge = (fillCount <= lowLim) || (fillCount >= highLim);
  assign notEmpty = ~emptyNow;
  assign notFull  = ~fullNow;

  assign strobe.wrEn = wrGo;
  assign strobe.rdEn = rdGo;
  assign wrAddr      = wBin[ADDR_W-1:0];
  assign rdAddr      = rBin[ADDR_W-1:0];
endmodule

// File: rtl/fifoData.sv
module fifoData
  import fifoPkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 10
) (
  input  logic              loadClk,
  input  logic              unloadClk,
  input  fifoStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge loadClk) begin
    if (strobe.wrEn) store[wrAddr] <= dataIn;
  end

  always_ff @(posedge unloadClk) begin
    if (strobe.rdEn) dataOut <= store[rdAddr];
  end
endmodule

// File: rtl/dualClockFifo.sv
module dualClockFifo
  import fifoPkg::*;
#(
  parameter int DATA_W    = 9,
  parameter int ADDR_W    = 10,
  parameter int DEFAULT_X = 256
) (
  input  logic              loadClk,
  input  logic              unloadClk,
  input  logic              rstN,
  input  logic              defineN,
  input  logic              loadEn,
  input  logic              unloadEn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              notEmpty,
  output logic              notFull,
  output logic              halfFull,
  output logic              nearEdge
);
  fifoStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  fifoCtrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEFAULT_X(DEFAULT_X), .SYNC_LEN(2)) i_ctrl (
    .loadClk(loadClk), .unloadClk(unloadClk), .rstN(rstN), .defineN(defineN),
    .loadEn(loadEn), .unloadEn(unloadEn), .dataIn(dataIn),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .notEmpty(notEmpty), .notFull(notFull), .halfFull(halfFull), .nearEdge(nearEdge));

  fifoData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_data (
    .loadClk(loadClk), .unloadClk(unloadClk), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .dataIn(dataIn), .dataOut(dataOut));
endmodule

// File: rtl/dualClockFifoChk.sv
module dualClockFifoChk #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 10
) (
  input logic              loadClk,
  input logic              unloadClk,
  input logic              rstN,
  input logic              loadEn,
  input logic              unloadEn,
  input logic              notEmpty,
  input logic              notFull,
  input logic              halfFull,
  input logic              nearEdge,
  input logic [DATA_W-1:0] dataOut,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr
);
  // R1: every accepted write moves the write position by exactly one
  a_r1_write_advance: assert property (@(posedge loadClk) disable iff (!rstN)
    wrEn |=> wrAddr == ADDR_W'($past(wrAddr) + 1'b1));

  // R1: every accepted read moves the read position by exactly one
  a_r1_read_advance: assert property (@(posedge unloadClk) disable iff (!rstN)
    rdEn |=> rdAddr == ADDR_W'($past(rdAddr) + 1'b1));

  // R2: a load request against a full store leaves the write position alone
  a_r2_full_blocks: assert property (@(posedge loadClk) disable iff (!rstN)
    (loadEn && !notFull) |=> $stable(wrAddr));

  // R3: an unload request against an empty store changes neither position nor output
  a_r3_empty_holds: assert property (@(posedge unloadClk) disable iff (!rstN)
    (unloadEn && !notEmpty) |=> ($stable(rdAddr) && $stable(dataOut)));

  // R5: the upper half can only be reported while words are present
  a_r5_half_has_data: assert property (@(posedge unloadClk) disable iff (!rstN)
    halfFull |-> notEmpty);

  // R6: an empty store is always within any offset of empty
  a_r6_empty_is_near: assert property (@(posedge unloadClk) disable iff (!rstN)
    !notEmpty |-> nearEdge);
endmodule

bind dualClockFifo dualClockFifoChk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .loadClk(loadClk), .unloadClk(unloadClk), .rstN(rstN),
  .loadEn(loadEn), .unloadEn(unloadEn),
  .notEmpty(notEmpty), .notFull(notFull), .halfFull(halfFull), .nearEdge(nearEdge),
  .dataOut(dataOut), .wrEn(strobe.wrEn), .rdEn(strobe.rdEn),
  .wrAddr(wrAddr), .rdAddr(rdAddr));

// File: tb/test_dualClockFifo.sv
`timescale 1ns/1ps
module test_dualClockFifo;
  localparam int DEPTH = 1024;

  logic       loadClk = 0, unloadClk = 0;
  logic       rstN = 0, defineN = 1, loadEn = 0, unloadEn = 0;
  logic [8:0] dataIn = 0;
  logic [8:0] dataOut;
  logic       notEmpty, notFull, halfFull, nearEdge;

  dualClockFifo i_dualClockFifo (
    .loadClk(loadClk), .unloadClk(unloadClk), .rstN(rstN), .defineN(defineN),
    .loadEn(loadEn), .unloadEn(unloadEn), .dataIn(dataIn), .dataOut(dataOut),
    .notEmpty(notEmpty), .notFull(notFull), .halfFull(halfFull), .nearEdge(nearEdge));

  always #4    loadClk   = ~loadClk;   // 125 MHz
  always #5.65 unloadClk = ~unloadClk; // unrelated period

  int tests = 0, fails = 0;
  int q[$];
  int modelX = 256;
  int wMode = 0, rMode = 0;   // 0 idle, 1 budget (write only), 2 always, 3 random
  int wBudget = 0;
  int nextData = 1;
  logic [8:0] defData = 0;
  bit popPending = 0, lastValid = 0, done = 0;
  int expOut = 0, lastOut = 0;

  task automatic check(bit ok, string msg, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  // Load side: drive at falling edge, decide acceptance from stable flags.
  always @(negedge loadClk) begin
    case (wMode)
      1:       loadEn = (wBudget > 0);
      2:       loadEn = 1'b1;
      3:       loadEn = 1'($urandom_range(0, 1));
      default: loadEn = 1'b0;
    endcase
    dataIn = (wMode == 0) ? defData : nextData[8:0];
    #1;
    if (rstN) begin
      check(!(notFull && q.size() >= DEPTH), "R10 notFull while store full", int'(notFull), 0);
      if (loadEn && notFull) begin
        q.push_back(int'(dataIn));
        nextData++;
        if (wMode == 1) wBudget--;
      end
    end
  end

  // Unload side: check last accepted read, then drive the next request.
  always @(negedge unloadClk) begin
    if (popPending) begin
      check(int'(dataOut) == expOut, "R1 read order", int'(dataOut), expOut);
      lastOut = expOut; lastValid = 1; popPending = 0;
    end else if (lastValid && rstN) begin
      check(int'(dataOut) == lastOut, "R3 output held without accepted read", int'(dataOut), lastOut);
    end
    case (rMode)
      2:       unloadEn = 1'b1;
      3:       unloadEn = 1'($urandom_range(0, 1));
      default: unloadEn = 1'b0;
    endcase
    #1;
    if (rstN) begin
      check(!(notEmpty && q.size() == 0), "R10 notEmpty while store empty", int'(notEmpty), 0);
      if (unloadEn && notEmpty && q.size() > 0) begin
        expOut = q.pop_front();
        popPending = 1;
      end
    end
  end

  task automatic settle();
    wMode = 0; rMode = 0;
    repeat (8) @(negedge unloadClk);
    @(negedge loadClk); #2;
  endtask

  task automatic checkFlags(string tag);
    int n = q.size();
    check(notEmpty == (n > 0),     {"R4 notEmpty ", tag}, int'(notEmpty), int'(n > 0));
    check(notFull  == (n < DEPTH), {"R4 notFull ", tag},  int'(notFull),  int'(n < DEPTH));
    check(halfFull == (n >= 512),  {"R5 halfFull ", tag}, int'(halfFull), int'(n >= 512));
    check(nearEdge == (n <= modelX || n >= DEPTH - modelX),
          {"R6 nearEdge ", tag}, int'(nearEdge), int'(n <= modelX || n >= DEPTH - modelX));
  endtask

  task automatic pushN(int n);
    wBudget = n; wMode = 1;
    wait (wBudget == 0);
    settle();
  endtask

  task automatic drain();
    wMode = 0; rMode = 2;
    wait (q.size() == 0);
    @(negedge unloadClk);
    settle();
  endtask

  task automatic doReset(logic defLevel, int xAfter);
    wMode = 0; rMode = 0;
    @(negedge loadClk);
    defineN = defLevel;
    rstN = 0;
    repeat (6) @(negedge loadClk);
    q.delete(); popPending = 0;
    rstN = 1;
    repeat (6) @(negedge unloadClk);
    modelX = xAfter;
    settle();
  endtask

  initial begin
    repeat (10) @(negedge loadClk);
    doReset(1'b1, 256);
    checkFlags("R9 after reset");

    // Threshold and half boundaries with the default offset (R6, R5, R8)
    pushN(256);  checkFlags("R8 default X count 256");
    pushN(1);    checkFlags("count 257");
    pushN(254);  checkFlags("count 511");
    pushN(1);    checkFlags("count 512");
    pushN(255);  checkFlags("count 767");
    pushN(1);    checkFlags("count 768");
    pushN(256);  checkFlags("count 1024 full");

    // R2: requests against a full store
    wMode = 2; repeat (20) @(negedge loadClk);
    settle();
    checkFlags("R2 after writes while full");
    check(q.size() == DEPTH, "R2 model count", q.size(), DEPTH);

    // R1: drain all, order checked per read; then R3 reads while empty
    drain();
    checkFlags("R1 drained");
    rMode = 2; repeat (20) @(negedge unloadClk);
    settle();
    checkFlags("R3 after reads while empty");

    // Concurrent random traffic (R1, R10)
    wMode = 3; rMode = 3;
    repeat (3000) @(negedge loadClk);
    drain();
    checkFlags("R1 after random traffic");

    // R7: capture a user offset, then commit it in reset (R8)
    @(negedge loadClk);
    defData = 9'd100;
    repeat (3) @(negedge loadClk);
    defineN = 0;
    repeat (6) @(negedge loadClk);
    doReset(1'b0, 100);
    checkFlags("R7 user X empty");
    pushN(100);  checkFlags("R7 user X count 100");
    pushN(1);    checkFlags("R7 user X count 101");
    pushN(822);  checkFlags("R7 user X count 923");
    pushN(1);    checkFlags("R7 user X count 924");

    // R8: another reset with the strobe still low keeps the user offset
    doReset(1'b0, 100);
    pushN(101);  checkFlags("R8 kept X count 101");

    // R8: reset with the strobe high restores the default
    doReset(1'b1, 256);
    pushN(101);  checkFlags("R8 default restored count 101");
    drain();
    checkFlags("R4 final empty");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule